// File: doc/BRIEF.md
# Embedded Word-Clock Deserializer

This block recovers fixed-width parallel words from a two-wire serial link: a bit clock and a data line driven by a matching serializer. Both lines are oversampled by a faster local clock. Data is captured on each rising edge of the received bit clock. Word alignment is derived solely from the received clock: the serializer marks the end of each word by holding its clock high for about three phase times instead of one. When that long high phase ends, the deserializer checks the frame it has collected. If the frame is well formed, it drops the two trailing marker bits and publishes the payload together with a one-cycle valid pulse.

Alignment is rebuilt at every marker, so a lost or extra bit damages at most the frame it falls in. A direction input decides whether the parallel word pins are driven or left floating. This allows the pins to be shared with a transmit path elsewhere.

Top module: `ewc_deser`

## Requirements
- R1: A frame is WORD_W+2 bits sent most significant payload bit first. The first received bit lands in word_o[WORD_W-1], and the last payload bit lands in word_o[0]. The two bits that follow it are markers and never appear on word_o.
- R2: sclk_i and sdat_i each pass through two local-clock flops. sdat_i is taken on each detected rising edge of the synchronised sclk_i.
- R3: A marker is recognised only when sclk_i has been seen high for more than 2*HALF_TICKS consecutive local cycles. A high run of exactly 2*HALF_TICKS cycles is an ordinary bit.
- R4: A frame is judged when a marker high run ends, meaning on the falling edge of sclk_i. A good frame raises word_valid_o for exactly one cycle, and word_o updates in that same cycle. word_o then holds its value until the next good frame.
- R5: A frame counts as good only if exactly WORD_W+2 rising edges arrived since the previous marker ended. Any other count raises frame_err_o for one cycle and gives no valid pulse.
- R6: A frame counts as good only if the first marker bit is the inverse of the last payload bit and the second marker bit equals it. Otherwise frame_err_o pulses and no valid pulse is given.
- R7: After reset, word_o is 0 and both pulses are low. The first marker seen after reset only establishes alignment: it produces neither word_valid_o nor frame_err_o.
- R8: Every marker restarts the bit count. A good frame that follows a damaged one is delivered normally.
- R9: With dir_i low, word_o drives the held word. With dir_i high, word_o is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Received serial bit clock |
| sdat_i | input | 1 | Received serial data |
| dir_i | input | 1 | 0: drive word_o, 1: float word_o |
| word_o | output | WORD_W | Recovered parallel word (tri-state) |
| word_valid_o | output | 1 | One-cycle pulse when a new word is published |
| frame_err_o | output | 1 | One-cycle pulse when a judged frame is rejected |

## Verification
Payloads with all bits set, all bits clear, alternating patterns of both phases, and values that differ only at the first or last bit are sent. These separate bit-order and marker-polarity faults, because the marker bits follow the last payload bit. Frames with the wrong marker polarity, frames one bit short or one bit long, and a mid-frame high phase exactly at the threshold or one cycle over it probe the acceptance rule. The threshold pair tells a correct comparison from an inclusive one. Good frames sent after each damaged one show that realignment happens, and toggling the direction while a known word is held shows the pins floating against a pull-up.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  localparam int unsigned BND_BITS = 2;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        stab_q <= meta_q;
      end
    end
    assign q_o[g] = stab_q;
  end
endmodule

// File: rtl/ewc_edge.sv
module ewc_edge
  import ewc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  output edge_t ev_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign ev_o.lvl  = lvl_i;
  assign ev_o.rise = lvl_i & ~prev_q;
  assign ev_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/ewc_bnd.sv
module ewc_bnd #(
  parameter int unsigned HALF_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic fall_i,
  output logic bnd_end_o
);
  localparam int unsigned THRESH = 2 * HALF_TICKS;
  localparam int unsigned SAT    = THRESH + 1;
  localparam int unsigned CW     = $clog2(SAT + 1);

  logic [CW-1:0] hi_cnt_q;

  // length of the current/last high run, saturating just above threshold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hi_cnt_q <= '0;
    else if (!lvl_i)                hi_cnt_q <= '0;
    else if (hi_cnt_q != CW'(SAT))  hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assign bnd_end_o = fall_i && (hi_cnt_q > CW'(THRESH));

  AST_BND_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_end_o |-> $past(lvl_i)); // R3
endmodule

// File: rtl/ewc_frame.sv
module ewc_frame
  import ewc_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              dat_i,
  input  logic              bnd_end_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int unsigned FRAME_BITS = WORD_W + BND_BITS;

  logic [FRAME_BITS-1:0] sr_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  armed_q;
  logic [WORD_W-1:0]     word_q;
  logic                  valid_q, err_q;
  logic                  frame_ok;

  // sr_q[1] / sr_q[0] are the two marker bits, sr_q[2] the last payload bit
  assign frame_ok = (cnt_q == CNT_W'(FRAME_BITS))
                 && (sr_q[1] == ~sr_q[2])
                 && (sr_q[0] ==  sr_q[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      word_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      if (bnd_end_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        if (armed_q) begin
          if (frame_ok) begin
            word_q  <= sr_q[FRAME_BITS-1:BND_BITS];
            valid_q <= 1'b1;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (rise_i) begin
        sr_q <= {sr_q[FRAME_BITS-2:0], dat_i};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R4
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(word_q)); // R4
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q); // R5
  AST_VALID_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(armed_q)); // R7
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_end_i |=> (cnt_q <= CNT_W'(1))); // R8
endmodule

// File: rtl/ewc_deser.sv
module ewc_deser
  import ewc_pkg::*;
#(
  parameter int unsigned WORD_W     = 24,
  parameter int unsigned HALF_TICKS = 4,
  parameter int unsigned CNT_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              dir_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              frame_err_o
);
  logic [1:0]        s_q;
  edge_t             ev;
  logic              bnd_end;
  logic [WORD_W-1:0] word;

  ewc_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, sdat_i}),
    .q_o   (s_q)
  );

  ewc_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (s_q[1]),
    .ev_o  (ev)
  );

  ewc_bnd #(.HALF_TICKS(HALF_TICKS)) u_bnd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (ev.lvl),
    .fall_i   (ev.fall),
    .bnd_end_o(bnd_end)
  );

  ewc_frame #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (ev.rise),
    .dat_i    (s_q[0]),
    .bnd_end_i(bnd_end),
    .word_o   (word),
    .valid_o  (word_valid_o),
    .err_o    (frame_err_o)
  );

  assign word_o = dir_i ? {WORD_W{1'bz}} : word;

  AST_NO_DOUBLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_valid_o && frame_err_o)); // R5
endmodule

// File: tb/ewc_deser_tb.sv
module ewc_deser_tb;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, dir = 1'b0;
  tri1 [23:0] word_bus;
  logic vld, err;

  int checks = 0, errors = 0;
  int vld_cnt = 0, err_cnt = 0, run = 0, max_run = 0;
  logic [23:0] last_word = '0;

  always #5 clk = ~clk;

  ewc_deser u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat), .dir_i(dir),
    .word_o(word_bus), .word_valid_o(vld), .frame_err_o(err)
  );

  always @(negedge clk) begin
    if (vld) begin
      vld_cnt++;
      last_word = word_bus;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
    if (err) err_cnt++;
  end

  localparam logic [23:0] VEC [8] = '{24'hFFFFFF, 24'h000000, 24'h555555, 24'hAAAAAA,
                                      24'h800000, 24'h000001, 24'h7FFFFE, 24'h123456};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fr(input logic [23:0] w);
    return {6'b0, w, ~w[0], w[0]};
  endfunction

  // n bits MSB first; last bit gets the long marker high; bit sp_idx gets sp_hi
  task automatic send(input logic [31:0] bits, input int n, input int sp_idx, input int sp_hi);
    for (int i = 0; i < n; i++) begin
      int hi;
      @(negedge clk);
      sdat = bits[n-1-i];
      sclk = 1'b0;
      repeat (H - 1) @(negedge clk);
      @(negedge clk);
      sclk = 1'b1;
      hi = (i == n - 1) ? 3 * H : (i == sp_idx ? sp_hi : H);
      repeat (hi - 1) @(negedge clk);
    end
    @(negedge clk);
    sclk = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input int dv, input int de,
                              input logic [23:0] w, input int v0, input int e0);
    chk({req, " valid"}, vld_cnt - v0, dv);
    chk({req, " err"}, err_cnt - e0, de);
    chk({req, " word"}, {8'h0, last_word}, {8'h0, w});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v0, e0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 reset word", {8'h0, word_bus}, 32'h0);
    chk("R7 reset valid", {31'h0, vld}, 32'h0);
    chk("R7 reset err", {31'h0, err}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 first marker only arms
    v0 = vld_cnt; e0 = err_cnt;
    send(fr(24'hA5A5A5), 26, -1, 0);
    expect_frame("R7 first marker", 0, 0, 24'h0, v0, e0);

    // R1 R2 R4 table walk
    for (int k = 0; k < 8; k++) begin
      v0 = vld_cnt; e0 = err_cnt;
      send(fr(VEC[k]), 26, -1, 0);
      expect_frame("R1 R2 R4 table", 1, 0, VEC[k], v0, e0);
    end
    chk("R4 pulse width", max_run, 1);

    // R6 wrong first marker bit
    v0 = vld_cnt; e0 = err_cnt;
    send({6'b0, 24'h0F0F0F, 1'b1, 1'b1}, 26, -1, 0);
    expect_frame("R6 marker1", 0, 1, 24'h123456, v0, e0);
    v0 = vld_cnt; e0 = err_cnt;
    send(fr(24'h0F0F0F), 26, -1, 0);
    expect_frame("R8 recover", 1, 0, 24'h0F0F0F, v0, e0);

    // R6 wrong second marker bit
    v0 = vld_cnt; e0 = err_cnt;
    send({6'b0, 24'h333332, 1'b1, 1'b1}, 26, -1, 0);
    expect_frame("R6 marker2", 0, 1, 24'h0F0F0F, v0, e0);

    // R5 short and long frames
    v0 = vld_cnt; e0 = err_cnt;
    send(fr(24'hC3C3C3), 25, -1, 0);
    expect_frame("R5 short", 0, 1, 24'h0F0F0F, v0, e0);
    v0 = vld_cnt; e0 = err_cnt;
    send(fr(24'hC3C3C3), 27, -1, 0);
    expect_frame("R5 long", 0, 1, 24'h0F0F0F, v0, e0);
    v0 = vld_cnt; e0 = err_cnt;
    send(fr(24'h3C3C3C), 26, -1, 0);
    expect_frame("R8 recover2", 1, 0, 24'h3C3C3C, v0, e0);

    // R3 threshold: exactly 2H is a bit, 2H+1 is a marker
    v0 = vld_cnt; e0 = err_cnt;
    send(fr(24'h654321), 26, 11, 2 * H);
    expect_frame("R3 at threshold", 1, 0, 24'h654321, v0, e0);
    v0 = vld_cnt; e0 = err_cnt;
    send(fr(24'h111111), 26, 11, 2 * H + 1);
    expect_frame("R3 over threshold", 0, 2, 24'h654321, v0, e0);
    v0 = vld_cnt; e0 = err_cnt;
    send(fr(24'h0000F0), 26, -1, 0);
    expect_frame("R8 recover3", 1, 0, 24'h0000F0, v0, e0);

    // R9 direction
    dir = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 float", {8'h0, word_bus}, 32'h00FFFFFF);
    dir = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 drive", {8'h0, word_bus}, 32'h000000F0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule